// File: doc/BRIEF.md
# SCSI DMA-Mode Handshake Responder

This block is the bus-facing half of an initiator-side SCSI controller while it runs in DMA mode. It turns each target REQ into an ACK handshake and paces that handshake with a host-side request/acknowledge pair (DRQ out, DACK in). In receive mode it captures the bus byte into an input register and waits for the host to take it. In send mode it asks the host for a byte, holds it in an output register, and puts it on the bus when the target requests it.

Handshakes run only while the phase programmed by the host equals the live bus phase lines. The transfer winds down on an end-of-process pulse, on a phase change or on a busy error (BSY lost during a transfer). In receive mode every REQ is still latched and acknowledged after end of DMA, and ACK stays high until DACK. This lets the host collect a final byte by hand before it leaves DMA mode. Status flags report phase match, end of DMA, busy error and last byte sent. An interrupt line can be enabled for end of DMA and for busy errors.

Top module: `scsi_dma_hs`

## Requirements
- R1: After reset, scsi_ack, dma_drq, irq, st_end_dma, st_busy_err and st_last_sent are all 0.
- R2: In receive mode, a REQ sampled while the phases match and ACK is low captures scsi_data_in into in_data and raises both scsi_ack and dma_drq on the next clock.
- R3: A receive handshake holds scsi_ack and dma_drq high, even after the target drops REQ, until a cycle with dack high. The clock after that cycle clears both.
- R4: Receive handshakes go on exactly as in R2 and R3 after end of DMA has been flagged.
- R5: When dma_mode is low at a clock edge, scsi_ack and dma_drq are low after that edge. in_data keeps the byte it holds.
- R6: st_phase_match is 1 only when scsi_phase equals tgt_phase. While they differ, REQ starts no handshake.
- R7: An eop pulse during an active transfer sets st_end_dma on the next clock. It is cleared by a start strobe or by dma_mode low.
- R8: BSY low during an active transfer sets st_busy_err on the next clock, after which REQ starts no handshake. The busy error raises irq only when bsy_mon_en is 1.
- R9: start_send takes effect only while drive_data is 1. In send mode dma_drq is high while the output buffer is empty. dack then loads host_wdata. A REQ with a loaded byte raises scsi_ack with that byte on scsi_data_out. scsi_ack falls on the clock after REQ is seen low.
- R10: After end of DMA in send mode, dma_drq stays low. st_last_sent rises once the buffer is empty and REQ and ACK are both low.
- R11: The start of end of DMA raises irq when eop_irq_en is 1. A status_rd pulse clears irq on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_mode | input | 1 | DMA mode enable (level) |
| bsy_mon_en | input | 1 | Busy error raises irq |
| eop_irq_en | input | 1 | End of DMA raises irq |
| drive_data | input | 1 | Host has enabled the data drivers |
| tgt_phase | input | PHASE_W | Expected bus phase |
| start_send | input | 1 | Start send strobe |
| start_recv | input | 1 | Start receive strobe |
| eop | input | 1 | End-of-process pulse |
| dack | input | 1 | Host DMA acknowledge |
| host_wdata | input | DATA_W | Byte from host, taken with dack in send mode |
| status_rd | input | 1 | Status read strobe, clears irq |
| scsi_req | input | 1 | Target REQ |
| scsi_bsy | input | 1 | Bus BSY |
| scsi_phase | input | PHASE_W | Live bus phase lines |
| scsi_data_in | input | DATA_W | Bus data |
| scsi_ack | output | 1 | Initiator ACK |
| scsi_data_out | output | DATA_W | Outgoing bus byte |
| scsi_data_oe | output | 1 | Data driver enable |
| dma_drq | output | 1 | Host DMA request |
| in_data | output | DATA_W | Input data register |
| st_phase_match | output | 1 | Phase match flag |
| st_end_dma | output | 1 | End of DMA flag |
| st_busy_err | output | 1 | Busy error flag |
| st_last_sent | output | 1 | Final send byte has left the bus |
| irq | output | 1 | Interrupt |

## Verification
A stuck transfer mode or a stale busy-error bit shows up one clock later as a handshake that should have happened but did not, or as an ACK with no REQ behind it. A handshake state that is off by one either drops ACK before DACK or keeps DRQ high after DACK, and this is visible on the first clock after the host cycle. Wrong buffer tracking in send mode puts the wrong byte under ACK, so the scoreboard catches it on that byte. The end-of-DMA and interrupt flags are read one clock after their cause, and again after the event that clears them.

// File: rtl/scsi_dma_pkg.sv
// Shared types for the DMA-mode handshake responder.
package scsi_dma_pkg;
    // Transfer direction selected by the start strobes.
    typedef enum logic [1:0] {
        XFER_IDLE = 2'd0,
        XFER_RECV = 2'd1,
        XFER_SEND = 2'd2
    } xfer_e;
endpackage

// File: rtl/dma_ctl.sv
// Transfer control: chooses the direction on start strobes and tracks the
// end-of-DMA, busy-error and last-byte-sent flags and the interrupt.
// Assumes all inputs are already synchronous to clk.
module dma_ctl
    import scsi_dma_pkg::*;
#(
    parameter bit HAS_LAST_SENT = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dma_mode,
    input  logic  drive_data,
    input  logic  start_send,
    input  logic  start_recv,
    input  logic  eop,
    input  logic  scsi_bsy,
    input  logic  scsi_req,
    input  logic  bsy_mon_en,
    input  logic  eop_irq_en,
    input  logic  status_rd,
    input  logic  tx_full,
    input  logic  tx_ack,
    output xfer_e mode,
    output logic  end_dma,
    output logic  busy_err,
    output logic  last_sent,
    output logic  irq
);
    logic rx_go, tx_go, active, restart, eop_ev, bsy_ev;

    assign rx_go   = dma_mode && start_recv;
    assign tx_go   = dma_mode && start_send && drive_data && !start_recv;
    assign restart = rx_go || tx_go;
    assign active  = dma_mode && (mode != XFER_IDLE);
    assign eop_ev  = active && eop && !end_dma;
    assign bsy_ev  = active && !scsi_bsy && !busy_err;

    // Direction register: set by a start strobe, dropped with DMA mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_mode) mode <= XFER_IDLE;
        else if (rx_go)          mode <= XFER_RECV;
        else if (tx_go)          mode <= XFER_SEND;
    end

    // End-of-DMA flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_mode || restart) end_dma <= 1'b0;
        else if (eop_ev)                    end_dma <= 1'b1;
    end

    // Busy-error flag: BSY lost during an active transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || !dma_mode || restart) busy_err <= 1'b0;
        else if (bsy_ev)                    busy_err <= 1'b1;
    end

    // Interrupt: set by enabled events, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          irq <= 1'b0;
        else if ((eop_ev && eop_irq_en) || (bsy_ev && bsy_mon_en)) irq <= 1'b1;
        else if (status_rd)                                  irq <= 1'b0;
    end

    generate
        if (HAS_LAST_SENT) begin : g_last
            // Last-byte-sent flag: send ended and bus handshake idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !dma_mode || restart) last_sent <= 1'b0;
                else if (mode == XFER_SEND && end_dma && !tx_full && !tx_ack && !scsi_req)
                    last_sent <= 1'b1;
            end
        end else begin : g_no_last
            assign last_sent = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/dma_rx_hs.sv
// Receive handshake: latches the bus byte and raises ACK and DRQ on REQ,
// holding both until the host acknowledges. It keeps running after end of
// DMA. Assumes the target drops REQ once it sees ACK.
module dma_rx_hs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hs_ok,
    input  logic              req,
    input  logic              dack,
    input  logic [DATA_W-1:0] din,
    output logic              ack,
    output logic              drq,
    output logic [DATA_W-1:0] data
);
    // Handshake state: capture on REQ, release on DACK.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ack <= 1'b0;
            drq <= 1'b0;
        end else if (ack && dack) begin
            ack <= 1'b0;
            drq <= 1'b0;
        end else if (hs_ok && req && !ack) begin
            ack <= 1'b1;
            drq <= 1'b1;
        end
    end

    // Input data register: survives a DMA mode drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data <= '0;
        else if (run && hs_ok && req && !ack)   data <= din;
    end
endmodule

// File: rtl/dma_tx_hs.sv
// Send handshake: asks the host for a byte, buffers it, and presents it
// with ACK on REQ; ACK falls once REQ is low. Fetching stops at end of DMA.
module dma_tx_hs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              hs_ok,
    input  logic              fetch_ok,
    input  logic              req,
    input  logic              dack,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic              drq,
    output logic              full,
    output logic [DATA_W-1:0] dout
);
    assign drq = run && !full && fetch_ok;

    // Buffer occupancy and bus ACK.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            full <= 1'b0;
            ack  <= 1'b0;
        end else begin
            if (drq && dack)                      full <= 1'b1;
            else if (!ack && full && hs_ok && req) full <= 1'b0;
            if (!ack && full && hs_ok && req)     ack <= 1'b1;
            else if (ack && !req)                 ack <= 1'b0;
        end
    end

    // Output data register, loaded from the host.
    always_ff @(posedge clk) begin
        if (!rst_n)           dout <= '0;
        else if (drq && dack) dout <= wdata;
    end
endmodule

// File: rtl/scsi_dma_hs.sv
// DMA-mode handshake responder top. Compares the host-programmed phase with
// the live bus phase, gates both handshake paths with it, and merges their
// ACK and DRQ. Assumes synchronous inputs and a single host DMA channel.
module scsi_dma_hs
    import scsi_dma_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int PHASE_W       = 3,
    parameter bit HAS_LAST_SENT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dma_mode,
    input  logic               bsy_mon_en,
    input  logic               eop_irq_en,
    input  logic               drive_data,
    input  logic [PHASE_W-1:0] tgt_phase,
    input  logic               start_send,
    input  logic               start_recv,
    input  logic               eop,
    input  logic               dack,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               status_rd,
    input  logic               scsi_req,
    input  logic               scsi_bsy,
    input  logic [PHASE_W-1:0] scsi_phase,
    input  logic [DATA_W-1:0]  scsi_data_in,
    output logic               scsi_ack,
    output logic [DATA_W-1:0]  scsi_data_out,
    output logic               scsi_data_oe,
    output logic               dma_drq,
    output logic [DATA_W-1:0]  in_data,
    output logic               st_phase_match,
    output logic               st_end_dma,
    output logic               st_busy_err,
    output logic               st_last_sent,
    output logic               irq
);
    xfer_e mode;
    logic  hs_ok, rx_run, tx_run;
    logic  rx_ack, rx_drq, tx_ack, tx_drq, tx_full;

    assign st_phase_match = (scsi_phase == tgt_phase);
    assign hs_ok          = st_phase_match && !st_busy_err;
    assign rx_run         = dma_mode && (mode == XFER_RECV);
    assign tx_run         = dma_mode && (mode == XFER_SEND);
    assign scsi_ack       = rx_ack | tx_ack;
    assign dma_drq        = rx_drq | tx_drq;
    assign scsi_data_oe   = tx_run && drive_data;

    dma_ctl #(.HAS_LAST_SENT(HAS_LAST_SENT)) u_ctl (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .drive_data(drive_data),
        .start_send(start_send), .start_recv(start_recv), .eop(eop),
        .scsi_bsy(scsi_bsy), .scsi_req(scsi_req), .bsy_mon_en(bsy_mon_en),
        .eop_irq_en(eop_irq_en), .status_rd(status_rd), .tx_full(tx_full),
        .tx_ack(tx_ack), .mode(mode), .end_dma(st_end_dma),
        .busy_err(st_busy_err), .last_sent(st_last_sent), .irq(irq)
    );

    dma_rx_hs #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .run(rx_run), .hs_ok(hs_ok), .req(scsi_req),
        .dack(dack), .din(scsi_data_in), .ack(rx_ack), .drq(rx_drq), .data(in_data)
    );

    dma_tx_hs #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .run(tx_run), .hs_ok(hs_ok),
        .fetch_ok(!st_end_dma && !st_busy_err), .req(scsi_req), .dack(dack),
        .wdata(host_wdata), .ack(tx_ack), .drq(tx_drq), .full(tx_full),
        .dout(scsi_data_out)
    );
endmodule

// File: rtl/scsi_dma_hs_chk.sv
// Port-level properties of the handshake responder, bound to the top.
module scsi_dma_hs_chk (
    input logic clk,
    input logic rst_n,
    input logic dma_mode,
    input logic dack,
    input logic start_send,
    input logic start_recv,
    input logic scsi_req,
    input logic scsi_ack,
    input logic dma_drq,
    input logic st_phase_match,
    input logic st_end_dma,
    input logic st_busy_err,
    input logic irq,
    input logic eop_irq_en,
    input logic bsy_mon_en
);
    // R5
    mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> (!scsi_ack && !dma_drq));
    // R6
    ack_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scsi_ack) |-> $past(st_phase_match));
    // R3
    ack_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scsi_ack) |-> ($past(dack) || !$past(dma_mode) || !$past(scsi_req)
                              || $past(start_send) || $past(start_recv)));
    // R7
    end_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> !st_end_dma);
    // R8
    busy_blocks_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_busy_err && dma_mode) |=> !$rose(scsi_ack));
    // R11
    irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(eop_irq_en || bsy_mon_en));
endmodule

bind scsi_dma_hs scsi_dma_hs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .dack(dack),
    .start_send(start_send), .start_recv(start_recv), .scsi_req(scsi_req),
    .scsi_ack(scsi_ack), .dma_drq(dma_drq), .st_phase_match(st_phase_match),
    .st_end_dma(st_end_dma), .st_busy_err(st_busy_err), .irq(irq),
    .eop_irq_en(eop_irq_en), .bsy_mon_en(bsy_mon_en)
);

// File: tb/test_scsi_dma_hs.sv
// Scoreboard bench: stimulus tasks push expected bytes, a monitor pops one
// on every rising ACK and compares it with the design's data register.
module test_scsi_dma_hs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dma_mode = 0, bsy_mon_en = 0, eop_irq_en = 0, drive_data = 0;
    logic [2:0] tgt_phase = 3'b001;
    logic       start_send = 0, start_recv = 0, eop = 0, dack = 0, status_rd = 0;
    logic [7:0] host_wdata = 0;
    logic       scsi_req = 0, scsi_bsy = 1;
    logic [2:0] scsi_phase = 3'b001;
    logic [7:0] scsi_data_in = 0;
    logic       scsi_ack, scsi_data_oe, dma_drq;
    logic [7:0] scsi_data_out, in_data;
    logic       st_phase_match, st_end_dma, st_busy_err, st_last_sent, irq;

    int   total = 0, bad = 0;
    bit   tx_side = 0;
    bit   prev_ack = 0;
    logic [7:0] sb_q[$];

    always #4 clk = ~clk;

    scsi_dma_hs i_scsi_dma_hs (
        .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .bsy_mon_en(bsy_mon_en),
        .eop_irq_en(eop_irq_en), .drive_data(drive_data), .tgt_phase(tgt_phase),
        .start_send(start_send), .start_recv(start_recv), .eop(eop), .dack(dack),
        .host_wdata(host_wdata), .status_rd(status_rd), .scsi_req(scsi_req),
        .scsi_bsy(scsi_bsy), .scsi_phase(scsi_phase), .scsi_data_in(scsi_data_in),
        .scsi_ack(scsi_ack), .scsi_data_out(scsi_data_out), .scsi_data_oe(scsi_data_oe),
        .dma_drq(dma_drq), .in_data(in_data), .st_phase_match(st_phase_match),
        .st_end_dma(st_end_dma), .st_busy_err(st_busy_err),
        .st_last_sent(st_last_sent), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    // Monitor: on each rising ACK compare the byte against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && scsi_ack && !prev_ack) begin
            if (sb_q.size() == 0) check("R2 unexpected ack", 1, 0);
            else check(tx_side ? "R9 byte on bus" : "R2 byte latched",
                       tx_side ? scsi_data_out : in_data, sb_q.pop_front());
        end
        prev_ack = scsi_ack;
    end

    // Target sends one byte in receive mode; host takes it with DACK.
    task automatic rx_byte(input logic [7:0] b, input string tag);
        scsi_data_in = b; scsi_req = 1; sb_q.push_back(b);
        cyc();
        check({tag, " ack"}, scsi_ack, 1);
        check({tag, " drq"}, dma_drq, 1);
        scsi_req = 0;
        cyc();
        check("R3 ack held until dack", scsi_ack, 1);
        check("R3 drq held until dack", dma_drq, 1);
        dack = 1;
        cyc();
        dack = 0;
        check("R3 ack released", scsi_ack, 0);
        check("R3 drq released", dma_drq, 0);
    endtask

    // Host supplies one byte and the target takes it in send mode.
    task automatic tx_byte(input logic [7:0] b);
        check("R9 drq for empty buffer", dma_drq, 1);
        host_wdata = b; dack = 1; sb_q.push_back(b);
        cyc();
        dack = 0;
        check("R9 drq low when full", dma_drq, 0);
        scsi_req = 1;
        cyc();
        check("R9 ack on req", scsi_ack, 1);
        scsi_req = 0;
        cyc();
        check("R9 ack falls after req low", scsi_ack, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        check("R1 ack", scsi_ack, 0);
        check("R1 drq", dma_drq, 0);
        check("R1 irq", irq, 0);
        check("R1 flags", {st_end_dma, st_busy_err, st_last_sent}, 0);

        // Receive transfer
        dma_mode = 1; eop_irq_en = 1; start_recv = 1;
        cyc();
        start_recv = 0;
        rx_byte(8'hA5, "R2");
        rx_byte(8'h3C, "R2");

        // Phase mismatch
        scsi_phase = 3'b000; #1;
        check("R6 match flag low", st_phase_match, 0);
        scsi_req = 1;
        cyc(); check("R6 no ack on mismatch", scsi_ack, 0);
        cyc(); check("R6 no ack on mismatch", scsi_ack, 0);
        scsi_req = 0; scsi_phase = 3'b001; #1;
        check("R6 match flag high", st_phase_match, 1);

        // End of DMA and interrupt
        eop = 1;
        cyc();
        eop = 0;
        check("R7 end flag", st_end_dma, 1);
        check("R11 irq on end", irq, 1);
        status_rd = 1;
        cyc();
        status_rd = 0;
        check("R11 irq cleared", irq, 0);

        // Receive keeps going after end of DMA
        rx_byte(8'h96, "R4");

        // Leave DMA mode with a byte latched and acknowledged
        scsi_data_in = 8'h11; scsi_req = 1; sb_q.push_back(8'h11);
        cyc();
        scsi_req = 0;
        check("R4 ack after end", scsi_ack, 1);
        dma_mode = 0;
        cyc();
        check("R5 ack dropped", scsi_ack, 0);
        check("R5 drq dropped", dma_drq, 0);
        check("R5 in_data kept", in_data, 8'h11);
        check("R7 end flag cleared", st_end_dma, 0);

        // Busy error, monitoring off then on
        dma_mode = 1; start_recv = 1;
        cyc();
        start_recv = 0; scsi_bsy = 0;
        cyc();
        check("R8 busy error flag", st_busy_err, 1);
        check("R8 no irq unmonitored", irq, 0);
        scsi_req = 1; scsi_bsy = 1;
        cyc();
        check("R8 no ack after busy error", scsi_ack, 0);
        scsi_req = 0; dma_mode = 0;
        cyc();
        bsy_mon_en = 1; dma_mode = 1; start_recv = 1;
        cyc();
        start_recv = 0; scsi_bsy = 0;
        cyc();
        scsi_bsy = 1;
        check("R8 irq when monitored", irq, 1);
        status_rd = 1; dma_mode = 0;
        cyc();
        status_rd = 0;

        // Send transfer
        tgt_phase = 3'b000; scsi_phase = 3'b000; tx_side = 1;
        dma_mode = 1; start_send = 1;
        cyc();
        start_send = 0;
        check("R9 start ignored without drive", dma_drq, 0);
        drive_data = 1; start_send = 1;
        cyc();
        start_send = 0;
        tx_byte(8'h5A);
        tx_byte(8'hC3);
        eop = 1;
        cyc();
        eop = 0;
        check("R10 end flag", st_end_dma, 1);
        check("R10 no fetch after end", dma_drq, 0);
        cyc();
        check("R10 last byte sent", st_last_sent, 1);
        check("R9 scoreboard drained", sb_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule